// File: doc/BRIEF.md
# Flash Pin Ownership Arbiter

This block decides which of two engines drives the serial flash pins. One is an automatic read engine that fetches code at boot. The other is a queued SPI master driven by software. The block tracks three ownership states: off (the state after reset), master-owned and boot-owned. It moves between them on request pulses from the software side.

Taking the pins away from the boot engine is only safe once that engine has gone idle. A claim request therefore waits for the boot engine's busy input to go low. The wait is bounded by a count of one-microsecond ticks. If the budget runs out, the claim ends with an error and the owner does not change. Giving the pins back to the boot engine happens at once.

A transfer request is handled by the current state. In the off state it is rejected. In the master-owned state it is acknowledged. In the boot-owned state it starts a claim. The pin multiplexer takes its select from a register that follows the owner state. The pins therefore change source one clock edge after the owner changes.

Top module: `flash_own_arbiter`

## Requirements
- R1: After synchronous reset, `own_state` is 2'b00 (off). All response pulses are low. The flash pins carry the boot engine's outputs. Owner encoding: 2'b00 off, 2'b01 master, 2'b10 boot.
- R2: A `xfer_req` seen while off gives a one-cycle `xfer_err` at the next edge and leaves `own_state` unchanged. A `xfer_req` seen while master-owned gives a one-cycle `xfer_ok` at the next edge.
- R3: A claim seen while master-owned gives `claim_done` at the next edge, even if `boot_busy` is high. No waiting takes place.
- R4: A claim seen while off or boot-owned with `boot_busy` low makes the block master-owned and pulses `claim_done`, both at that same edge.
- R5: If `boot_busy` is high at the claim, the block waits. It does not become master-owned while `boot_busy` is high. It grants at the first edge that sees `boot_busy` low, provided the tick budget has not run out.
- R6: If `TIMEOUT_TICKS` ticks are seen while waiting with `boot_busy` high, `claim_err` pulses at the edge of the last of those ticks. The owner state does not change.
- R7: A new claim arriving during the wait restarts the tick count from zero. The tick at that edge is not counted.
- R8: `release_req` makes the block boot-owned at the next edge, whatever `boot_busy` is. A release that arrives during a wait is ignored.
- R9: The flash pins switch to the new owner's outputs one clock edge after `own_state` changes, and never sooner.
- R10: A `xfer_req` seen while boot-owned starts a claim. It follows the same rules as `claim_req` and gives no `xfer_ok`.
- R11: When a claim and a release arrive together, the claim wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| claim_req | input | 1 | Request master ownership (pulse) |
| release_req | input | 1 | Hand the pins back to the boot engine (pulse) |
| xfer_req | input | 1 | Transfer request (pulse) |
| boot_busy | input | 1 | Boot read engine busy flag |
| boot_sck | input | 1 | Boot engine serial clock |
| boot_cs_n | input | 1 | Boot engine chip select, active low |
| boot_dq_o | input | LANES | Boot engine data outputs |
| boot_dq_oe | input | LANES | Boot engine data output enables |
| mst_sck | input | 1 | Master serial clock |
| mst_cs_n | input | 1 | Master chip select, active low |
| mst_dq_o | input | LANES | Master data outputs |
| mst_dq_oe | input | LANES | Master data output enables |
| own_state | output | 2 | Current owner: 00 off, 01 master, 10 boot |
| claim_done | output | 1 | Claim granted or already held (pulse) |
| claim_err | output | 1 | Claim timed out (pulse) |
| xfer_ok | output | 1 | Transfer accepted (pulse) |
| xfer_err | output | 1 | Transfer rejected while off (pulse) |
| flash_sck | output | 1 | Serial clock to the flash |
| flash_cs_n | output | 1 | Chip select to the flash |
| flash_dq_o | output | LANES | Data to the flash |
| flash_dq_oe | output | LANES | Data output enables to the flash |

## Verification
The main stimulus is a sweep of claims started from the boot-owned state. The bench varies how many cycles `boot_busy` stays high and how many cycles separate ticks. This sweep tells a grant on the last tick apart from a timeout on that same tick, and shows that the count follows ticks rather than clock cycles. Further runs re-issue a claim mid-wait, which separates a restarted count from a running one. Others send a release during a wait, which shows whether an ignored release is truly ignored. Distinct, non-overlapping pin patterns on the two engines expose a mux that switches early, late or by the wrong field.

// File: rtl/flash_own_pkg.sv
package flash_own_pkg;

    typedef enum logic [1:0] {
        OWN_OFF    = 2'b00,
        OWN_MASTER = 2'b01,
        OWN_BOOT   = 2'b10
    } own_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        logic done;
        logic err;
    } claim_rsp_t;

    typedef struct packed {
        logic ok;
        logic err;
    } xfer_rsp_t;

    function automatic logic owner_is_master(input own_e o);
        return o == OWN_MASTER;
    endfunction

endpackage

// File: rtl/flash_own_timer.sv
module flash_own_timer #(
    parameter int TIMEOUT_TICKS = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || expired) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the count never passes the budget
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(TIMEOUT_TICKS));

endmodule

// File: rtl/flash_own_fsm.sv
module flash_own_fsm
    import flash_own_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic claim_req,
    input  logic release_req,
    input  logic xfer_req,
    input  logic boot_busy,
    input  logic tmo_expired,
    output own_e own_q,
    output logic waiting,
    output logic restart,
    output claim_rsp_t claim_rsp,
    output xfer_rsp_t xfer_rsp
);
    phase_e phase_q;
    logic   switch_req;

    assign switch_req = claim_req || (xfer_req && own_q == OWN_BOOT);
    assign waiting    = (phase_q == PH_WAIT);
    assign restart    = waiting && switch_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q     <= OWN_OFF;
            phase_q   <= PH_IDLE;
            claim_rsp <= '0;
            xfer_rsp  <= '0;
        end else begin
            claim_rsp    <= '0;
            xfer_rsp.ok  <= xfer_req && owner_is_master(own_q);
            xfer_rsp.err <= xfer_req && (own_q == OWN_OFF);
            case (phase_q)
                PH_IDLE: begin
                    if (switch_req) begin
                        if (owner_is_master(own_q)) begin
                            claim_rsp.done <= 1'b1;
                        end else if (!boot_busy) begin
                            own_q          <= OWN_MASTER;
                            claim_rsp.done <= 1'b1;
                        end else begin
                            phase_q <= PH_WAIT;
                        end
                    end else if (release_req) begin
                        own_q <= OWN_BOOT;
                    end
                end
                PH_WAIT: begin
                    if (!boot_busy) begin
                        own_q          <= OWN_MASTER;
                        claim_rsp.done <= 1'b1;
                        phase_q        <= PH_IDLE;
                    end else if (!restart && tmo_expired) begin
                        claim_rsp.err <= 1'b1;
                        phase_q       <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R5: no grant on an edge that sees the boot engine busy
    a_r5_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
        (own_q != OWN_MASTER && boot_busy) |=> (own_q != OWN_MASTER));

    // R6: a timeout leaves the owner where it was
    a_r6_err_keeps_owner: assert property (@(posedge clk) disable iff (rst)
        claim_rsp.err |-> $stable(own_q));

    // R3: claim while master answers at the next edge
    a_r3_master_immediate: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && own_q == OWN_MASTER && claim_req) |=> claim_rsp.done);

    // R8: a lone release while idle hands the pins to the boot engine
    a_r8_release_boot: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && release_req && !switch_req) |=> (own_q == OWN_BOOT));

    // R4: grant and timeout never coincide
    a_r4_done_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(claim_rsp.done && claim_rsp.err));

endmodule

// File: rtl/flash_pin_mux.sv
module flash_pin_mux #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_master_d,
    input  logic             boot_sck,
    input  logic             boot_cs_n,
    input  logic [LANES-1:0] boot_dq_o,
    input  logic [LANES-1:0] boot_dq_oe,
    input  logic             mst_sck,
    input  logic             mst_cs_n,
    input  logic [LANES-1:0] mst_dq_o,
    input  logic [LANES-1:0] mst_dq_oe,
    output logic             flash_sck,
    output logic             flash_cs_n,
    output logic [LANES-1:0] flash_dq_o,
    output logic [LANES-1:0] flash_dq_oe
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel_master_d;
    end

    assign flash_sck  = sel_q ? mst_sck  : boot_sck;
    assign flash_cs_n = sel_q ? mst_cs_n : boot_cs_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign flash_dq_o[g]  = sel_q ? mst_dq_o[g]  : boot_dq_o[g];
        assign flash_dq_oe[g] = sel_q ? mst_dq_oe[g] : boot_dq_oe[g];
    end

endmodule

// File: rtl/flash_own_arbiter.sv
module flash_own_arbiter
    import flash_own_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 200000,
    parameter int LANES         = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_us,
    input  logic             claim_req,
    input  logic             release_req,
    input  logic             xfer_req,
    input  logic             boot_busy,
    input  logic             boot_sck,
    input  logic             boot_cs_n,
    input  logic [LANES-1:0] boot_dq_o,
    input  logic [LANES-1:0] boot_dq_oe,
    input  logic             mst_sck,
    input  logic             mst_cs_n,
    input  logic [LANES-1:0] mst_dq_o,
    input  logic [LANES-1:0] mst_dq_oe,
    output logic [1:0]       own_state,
    output logic             claim_done,
    output logic             claim_err,
    output logic             xfer_ok,
    output logic             xfer_err,
    output logic             flash_sck,
    output logic             flash_cs_n,
    output logic [LANES-1:0] flash_dq_o,
    output logic [LANES-1:0] flash_dq_oe
);
    own_e       own_q;
    logic       waiting;
    logic       restart;
    logic       tmo_expired;
    claim_rsp_t claim_rsp;
    xfer_rsp_t  xfer_rsp;

    flash_own_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .claim_req   (claim_req),
        .release_req (release_req),
        .xfer_req    (xfer_req),
        .boot_busy   (boot_busy),
        .tmo_expired (tmo_expired),
        .own_q       (own_q),
        .waiting     (waiting),
        .restart     (restart),
        .claim_rsp   (claim_rsp),
        .xfer_rsp    (xfer_rsp)
    );

    flash_own_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (!waiting || restart),
        .run     (waiting && boot_busy && !restart),
        .tick    (tick_us),
        .expired (tmo_expired)
    );

    flash_pin_mux #(.LANES(LANES)) u_mux (
        .clk          (clk),
        .rst          (rst),
        .sel_master_d (owner_is_master(own_q)),
        .boot_sck     (boot_sck),
        .boot_cs_n    (boot_cs_n),
        .boot_dq_o    (boot_dq_o),
        .boot_dq_oe   (boot_dq_oe),
        .mst_sck      (mst_sck),
        .mst_cs_n     (mst_cs_n),
        .mst_dq_o     (mst_dq_o),
        .mst_dq_oe    (mst_dq_oe),
        .flash_sck    (flash_sck),
        .flash_cs_n   (flash_cs_n),
        .flash_dq_o   (flash_dq_o),
        .flash_dq_oe  (flash_dq_oe)
    );

    assign own_state  = own_q;
    assign claim_done = claim_rsp.done;
    assign claim_err  = claim_rsp.err;
    assign xfer_ok    = xfer_rsp.ok;
    assign xfer_err   = xfer_rsp.err;

    // R9: a settled master owner sees the master's pins
    a_r9_master_pins: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_MASTER && $past(own_q) == OWN_MASTER)
            |-> (flash_cs_n == mst_cs_n && flash_dq_o == mst_dq_o));

    // R9: a settled non-master owner sees the boot engine's pins
    a_r9_boot_pins: assert property (@(posedge clk) disable iff (rst)
        (own_q != OWN_MASTER && $past(own_q) != OWN_MASTER)
            |-> (flash_cs_n == boot_cs_n && flash_dq_oe == boot_dq_oe));

endmodule

// File: tb/flash_own_arbiter_tb.sv
module flash_own_arbiter_tb_top;
    localparam int L     = 5;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_us = 0, claim_req = 0, release_req = 0, xfer_req = 0, boot_busy = 0;
    logic boot_sck = 1'b1, boot_cs_n = 1'b0, mst_sck = 1'b0, mst_cs_n = 1'b1;
    logic [LANES-1:0] boot_dq_o = 4'hA, boot_dq_oe = 4'hF;
    logic [LANES-1:0] mst_dq_o  = 4'h5, mst_dq_oe  = 4'h3;
    logic [1:0] own_state;
    logic claim_done, claim_err, xfer_ok, xfer_err;
    logic flash_sck, flash_cs_n;
    logic [LANES-1:0] flash_dq_o, flash_dq_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_own_arbiter #(.TIMEOUT_TICKS(L), .LANES(LANES)) dut_i (
        .clk(clk), .rst(rst), .tick_us(tick_us), .claim_req(claim_req),
        .release_req(release_req), .xfer_req(xfer_req), .boot_busy(boot_busy),
        .boot_sck(boot_sck), .boot_cs_n(boot_cs_n), .boot_dq_o(boot_dq_o),
        .boot_dq_oe(boot_dq_oe), .mst_sck(mst_sck), .mst_cs_n(mst_cs_n),
        .mst_dq_o(mst_dq_o), .mst_dq_oe(mst_dq_oe), .own_state(own_state),
        .claim_done(claim_done), .claim_err(claim_err), .xfer_ok(xfer_ok),
        .xfer_err(xfer_err), .flash_sck(flash_sck), .flash_cs_n(flash_cs_n),
        .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe)
    );

    localparam logic [9:0] BOOT_PINS = {1'b1, 1'b0, 4'hA, 4'hF};
    localparam logic [9:0] MST_PINS  = {1'b0, 1'b1, 4'h5, 4'h3};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req, input bit master);
        chk(req, {22'd0, flash_sck, flash_cs_n, flash_dq_o, flash_dq_oe},
            {22'd0, master ? MST_PINS : BOOT_PINS});
    endtask

    task automatic do_release();
        release_req = 1'b1;
        @(negedge clk);
        release_req = 1'b0;
        @(negedge clk);
    endtask

    // Claim with busy high for b edges, a tick every p edges, an optional
    // re-claim at edge rs and release at edge rl. Returns the edge of the outcome.
    task automatic run_claim(input int b, input int p, input int rs, input int rl,
                             output int jout, output bit got_done, output bit got_err);
        jout = -1; got_done = 0; got_err = 0;
        claim_req = 1'b1; boot_busy = (b > 0); tick_us = 1'b0;
        for (int j = 0; j < 200; j++) begin
            @(negedge clk);
            claim_req = 1'b0; release_req = 1'b0;
            if (claim_done || claim_err) begin
                jout = j; got_done = claim_done; got_err = claim_err;
                break;
            end
            boot_busy   = (j + 1 < b);
            tick_us     = ((j + 1) % p == 0);
            claim_req   = (j + 1 == rs);
            release_req = (j + 1 == rl);
        end
        boot_busy = 1'b0; tick_us = 1'b0; claim_req = 1'b0; release_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int jo;
        bit gd, ge;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 own", {30'd0, own_state}, 32'd0);
        chk("R1 pulses", {28'd0, claim_done, claim_err, xfer_ok, xfer_err}, 32'd0);
        chk_pins("R1 pins", 1'b0);

        // R2 transfer rejected while off
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        chk("R2 xfer_err off", {31'd0, xfer_err}, 32'd1);
        chk("R2 own off kept", {30'd0, own_state}, 32'd0);
        chk("R2 no ok off", {31'd0, xfer_ok}, 32'd0);

        // R8 release from off, boot busy does not matter
        boot_busy = 1'b1; release_req = 1'b1; @(negedge clk);
        release_req = 1'b0; boot_busy = 1'b0;
        chk("R8 release immediate", {30'd0, own_state}, 32'd2);

        // R4 R5 R6 R9 sweep over busy length and tick spacing
        for (int p = 1; p <= 3; p++) begin
            for (int b = 0; b <= L * p + 2; b++) begin
                run_claim(b, p, -1, -1, jo, gd, ge);
                if (b <= L * p) begin
                    chk($sformatf("R5 grant edge b=%0d p=%0d", b, p), jo, b);
                    chk($sformatf("R4 done b=%0d p=%0d", b, p), {31'd0, gd}, 32'd1);
                    chk("R4 own master", {30'd0, own_state}, 32'd1);
                    chk_pins("R9 pins lag one edge", 1'b0);
                    @(negedge clk);
                    chk_pins("R9 pins master", 1'b1);
                    do_release();
                    chk_pins("R9 pins back to boot", 1'b0);
                end else begin
                    chk($sformatf("R6 timeout edge b=%0d p=%0d", b, p), jo, L * p);
                    chk($sformatf("R6 err b=%0d p=%0d", b, p), {31'd0, ge}, 32'd1);
                    chk("R6 owner unchanged", {30'd0, own_state}, 32'd2);
                    @(negedge clk);
                    chk_pins("R6 pins stay boot", 1'b0);
                end
            end
        end

        // R7 re-claim at edge 4 restarts the count: error at 4+L, not L
        run_claim(100, 1, 4, -1, jo, gd, ge);
        chk("R7 restarted timeout edge", jo, 4 + L);
        chk("R7 err", {31'd0, ge}, 32'd1);
        chk("R7 owner", {30'd0, own_state}, 32'd2);

        // R8 release during the wait is ignored: grant still lands at edge 2
        run_claim(2, 1, -1, 1, jo, gd, ge);
        chk("R8 release in wait ignored edge", jo, 2);
        chk("R8 release in wait ignored own", {30'd0, own_state}, 32'd1);

        // R3 claim while master, busy high
        boot_busy = 1'b1; claim_req = 1'b1; @(negedge clk); claim_req = 1'b0;
        chk("R3 immediate done", {31'd0, claim_done}, 32'd1);
        chk("R3 own master", {30'd0, own_state}, 32'd1);

        // R2 transfer accepted while master
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        chk("R2 xfer_ok master", {31'd0, xfer_ok}, 32'd1);
        chk("R2 no err master", {31'd0, xfer_err}, 32'd0);

        // R11 claim beats release
        claim_req = 1'b1; release_req = 1'b1; @(negedge clk);
        claim_req = 1'b0; release_req = 1'b0;
        chk("R11 claim wins own", {30'd0, own_state}, 32'd1);
        chk("R11 claim wins done", {31'd0, claim_done}, 32'd1);

        // R8 release with busy high
        release_req = 1'b1; @(negedge clk); release_req = 1'b0; boot_busy = 1'b0;
        chk("R8 release while busy", {30'd0, own_state}, 32'd2);

        // R10 transfer from boot starts a claim
        @(negedge clk);
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        chk("R10 xfer claims", {30'd0, own_state}, 32'd1);
        chk("R10 done", {31'd0, claim_done}, 32'd1);
        chk("R10 no xfer_ok", {31'd0, xfer_ok}, 32'd0);

        // R10 transfer from boot with busy times out
        do_release();
        boot_busy = 1'b1; tick_us = 1'b1; xfer_req = 1'b1;
        @(negedge clk); xfer_req = 1'b0;
        repeat (L - 1) @(negedge clk);
        chk("R10 not yet err", {31'd0, claim_err}, 32'd0);
        @(negedge clk);
        chk("R10 xfer timeout err", {31'd0, claim_err}, 32'd1);
        chk("R10 owner kept", {30'd0, own_state}, 32'd2);
        boot_busy = 1'b0; tick_us = 1'b0;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule